// File: doc/BRIEF.md
# Edge Timestamp Capture Channel

This block records the time of edges on an external pin. A shared 16-bit free-running count, which advances once every four bus clocks outside the block, is sampled whenever the pin makes the transition chosen by an edge-select input. The sampled value goes into a capture register that software reads as a high byte and a low byte.

The pin first passes through a synchronizer chain. A copy of the count travels alongside it, so each timestamp belongs to the clock edge that first saw the new pin level. The stored value is that count plus one, which covers the synchronization delay. Two small state machines handle the rest.

The read-lock machine has states LK_OPEN and LK_HELD. A high-byte read takes it from LK_OPEN to LK_HELD, and a low-byte read takes it back. The flag machine has states FL_CLEAR, FL_SET and FL_ARMED. A qualifying edge moves it from FL_CLEAR or FL_ARMED to FL_SET. A status read moves it from FL_SET to FL_ARMED. A low-byte read moves it from FL_ARMED to FL_CLEAR. The interrupt request is the flag gated by an enable input.

Top module: `icu_capture_unit`

## Requirements
- R1: While and after reset the capture flag and the interrupt request are 0, and the read lock is open.
- R2: With edge_rise = 1, a low-to-high pin change stores (count seen at the first clock edge after the change) + 1, modulo 2^16. The value is visible on cap_hi/cap_lo three clocks after the change, and the capture flag rises in the same cycle.
- R3: With edge_rise = 0, only high-to-low pin changes capture. A pin change of the other polarity leaves the register and the flag unchanged.
- R4: Every qualifying edge overwrites the register, even while the flag is already set, so the register holds the most recent event.
- R5: A one-cycle pulse on rd_hi blocks transfers into the register until a pulse on rd_lo. Edges in that window still set the flag. An edge in the same cycle as the rd_hi pulse is also blocked.
- R6: A pulse on rd_lo without a preceding rd_hi pulse does not block later captures.
- R7: Reset leaves the contents of the capture register unchanged.
- R8: The flag is cleared by a pulse on rd_stat while the flag is set, followed by a pulse on rd_lo. A new qualifying edge after the status read re-sets the flag and cancels the pending clear.
- R9: A pulse on rd_lo while the flag is set but no status read has occurred leaves the flag set.
- R10: irq is 1 exactly when the flag is 1 and irq_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| pin_in | input | 1 | Asynchronous external event pin |
| cnt_in | input | 16 | Shared free-running count |
| edge_rise | input | 1 | 1 selects rising edges, 0 selects falling edges |
| irq_en | input | 1 | Capture interrupt enable |
| rd_stat | input | 1 | One-cycle strobe: status register read |
| rd_hi | input | 1 | One-cycle strobe: high byte of the capture register read |
| rd_lo | input | 1 | One-cycle strobe: low byte of the capture register read |
| cap_hi | output | 8 | Capture register, upper byte |
| cap_lo | output | 8 | Capture register, lower byte |
| cap_flag | output | 1 | Capture flag |
| irq | output | 1 | Capture interrupt request |

## Verification
A pin change driven at a falling clock edge passes through two synchronizer flops and one edge-detect compare. It updates the register and the flag at the third rising edge, so the bench samples both at the falling edge three clocks after the change. At that moment it also compares against the count it held when the pin moved, plus one. Each read strobe is held across exactly one rising edge, and its effect on the lock or the flag is checked at the falling edge that follows. The bench's count model steps shortly after each rising edge, so the value captured at a rising edge is never ambiguous.

// File: rtl/icu_pkg.sv
`timescale 1ns/1ps
package icu_pkg;

    typedef enum logic {
        LK_OPEN,
        LK_HELD
    } lock_state_t;

    typedef enum logic [1:0] {
        FL_CLEAR,
        FL_SET,
        FL_ARMED
    } flag_state_t;

endpackage

// File: rtl/icu_sync_edge.sv
`timescale 1ns/1ps
module icu_sync_edge #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_in,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic             edge_rise,
    output logic             edge_hit,
    output logic [CNT_W-1:0] cnt_tag
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] stage_q;
    logic                   level_prev_q;
    logic [CNT_W-1:0]       tag_q [SYNC_STAGES];

    // pin synchronizer and previous-level register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q      <= '0;
            level_prev_q <= 1'b0;
        end else begin
            stage_q      <= {stage_q[SYNC_STAGES-2:0], pin_in};
            level_prev_q <= stage_q[LAST];
        end
    end

    // count travels in step with the pin sample it belongs to
    always_ff @(posedge clk) begin
        tag_q[0] <= cnt_in;
    end

    generate
        for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_tag
            always_ff @(posedge clk) begin
                tag_q[g] <= tag_q[g-1];
            end
        end
    endgenerate

    always_comb begin
        if (edge_rise) begin
            edge_hit = stage_q[LAST] & ~level_prev_q;
        end else begin
            edge_hit = ~stage_q[LAST] & level_prev_q;
        end
    end

    assign cnt_tag = tag_q[LAST];

endmodule

// File: rtl/icu_read_lock.sv
`timescale 1ns/1ps
module icu_read_lock
    import icu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_hi,
    input  logic rd_lo,
    output logic xfer_ok
);
    lock_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        xfer_ok = 1'b0;
        unique case (state_q)
            LK_OPEN: begin
                xfer_ok = !rd_hi;
                if (rd_hi) begin
                    state_d = LK_HELD;
                end
            end
            LK_HELD: begin
                xfer_ok = 1'b0;
                if (rd_lo) begin
                    state_d = LK_OPEN;
                end
            end
            default: begin
                state_d = LK_OPEN;
            end
        endcase
    end

endmodule

// File: rtl/icu_flag_ctl.sv
`timescale 1ns/1ps
module icu_flag_ctl
    import icu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic edge_hit,
    input  logic rd_stat,
    input  logic rd_lo,
    output logic flag
);
    flag_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FL_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        flag    = 1'b1;
        unique case (state_q)
            FL_CLEAR: begin
                flag = 1'b0;
                if (edge_hit) begin
                    state_d = FL_SET;
                end
            end
            FL_SET: begin
                if (rd_stat && !edge_hit) begin
                    state_d = FL_ARMED;
                end
            end
            FL_ARMED: begin
                if (edge_hit) begin
                    state_d = FL_SET;
                end else if (rd_lo) begin
                    state_d = FL_CLEAR;
                end
            end
            default: begin
                state_d = FL_CLEAR;
            end
        endcase
    end

endmodule

// File: rtl/icu_capture_reg.sv
`timescale 1ns/1ps
module icu_capture_reg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             load,
    input  logic [CNT_W-1:0] cnt_tag,
    output logic [CNT_W-1:0] cap_q
);
    localparam logic [CNT_W-1:0] SYNC_OFFSET = CNT_W'(1);

    // no reset: contents survive a reset
    always_ff @(posedge clk) begin
        if (load) begin
            cap_q <= cnt_tag + SYNC_OFFSET;
        end
    end

endmodule

// File: rtl/icu_capture_unit.sv
`timescale 1ns/1ps
module icu_capture_unit #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int HALF_W     = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_in,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic              edge_rise,
    input  logic              irq_en,
    input  logic              rd_stat,
    input  logic              rd_hi,
    input  logic              rd_lo,
    output logic [HALF_W-1:0] cap_hi,
    output logic [HALF_W-1:0] cap_lo,
    output logic              cap_flag,
    output logic              irq
);
    logic             edge_hit;
    logic [CNT_W-1:0] cnt_tag;
    logic             xfer_ok;
    logic [CNT_W-1:0] cap_q;

    icu_sync_edge #(
        .CNT_W       (CNT_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .cnt_in    (cnt_in),
        .edge_rise (edge_rise),
        .edge_hit  (edge_hit),
        .cnt_tag   (cnt_tag)
    );

    icu_read_lock u_read_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_hi   (rd_hi),
        .rd_lo   (rd_lo),
        .xfer_ok (xfer_ok)
    );

    icu_flag_ctl u_flag_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_hit (edge_hit),
        .rd_stat  (rd_stat),
        .rd_lo    (rd_lo),
        .flag     (cap_flag)
    );

    icu_capture_reg #(
        .CNT_W (CNT_W)
    ) u_capture_reg (
        .clk     (clk),
        .load    (edge_hit & xfer_ok),
        .cnt_tag (cnt_tag),
        .cap_q   (cap_q)
    );

    assign cap_hi = cap_q[CNT_W-1:HALF_W];
    assign cap_lo = cap_q[HALF_W-1:0];
    assign irq    = cap_flag & irq_en;

endmodule

// File: rtl/icu_capture_chk.sv
`timescale 1ns/1ps
module icu_capture_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_hi,
    input logic             rd_lo,
    input logic             irq_en,
    input logic             edge_hit,
    input logic [CNT_W-1:0] cap_val,
    input logic             cap_flag,
    input logic             irq
);
    logic lock_mdl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_mdl <= 1'b0;
        end else if (!lock_mdl && rd_hi) begin
            lock_mdl <= 1'b1;
        end else if (lock_mdl && rd_lo) begin
            lock_mdl <= 1'b0;
        end
    end

    // R5
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hi || lock_mdl) |=> $stable(cap_val));

    // R4
    cap_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_val) |-> $past(edge_hit));

    // R2
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_flag) |-> $past(edge_hit));

    // R8
    flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cap_flag) |-> $past(rd_lo));

    // R10
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    // R10
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cap_flag);

endmodule

bind icu_capture_unit icu_capture_chk #(
    .CNT_W (CNT_W)
) u_capture_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_hi    (rd_hi),
    .rd_lo    (rd_lo),
    .irq_en   (irq_en),
    .edge_hit (edge_hit),
    .cap_val  ({cap_hi, cap_lo}),
    .cap_flag (cap_flag),
    .irq      (irq)
);

// File: tb/test_icu_capture_unit.sv
`timescale 1ns/1ps
module test_icu_capture_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_in = 1'b0;
    logic [15:0] cnt_in = 16'h0000;
    logic        edge_rise = 1'b1;
    logic        irq_en = 1'b0;
    logic        rd_stat = 1'b0;
    logic        rd_hi = 1'b0;
    logic        rd_lo = 1'b0;
    logic [7:0]  cap_hi, cap_lo;
    logic        cap_flag, irq;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    logic [1:0]  div = 2'd0;
    logic [15:0] snap = 16'h0;
    logic [15:0] held = 16'h0;

    // vector: {edge_rise, new pin level, capture expected}
    localparam logic [2:0] VEC [7] = '{
        3'b111, 3'b100, 3'b010, 3'b001, 3'b010, 3'b100, 3'b111
    };

    always #10 clk = ~clk;

    icu_capture_unit i_icu_capture_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .cnt_in    (cnt_in),
        .edge_rise (edge_rise),
        .irq_en    (irq_en),
        .rd_stat   (rd_stat),
        .rd_hi     (rd_hi),
        .rd_lo     (rd_lo),
        .cap_hi    (cap_hi),
        .cap_lo    (cap_lo),
        .cap_flag  (cap_flag),
        .irq       (irq)
    );

    // shared count: one step per four clocks, just after a rising edge
    always @(posedge clk) begin
        #1;
        if (div == 2'd3) cnt_in = cnt_in + 16'd1;
        div = div + 2'd1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pin_to(input logic sel, input logic lvl);
        @(negedge clk);
        edge_rise = sel;
        pin_in    = lvl;
        snap      = cnt_in;
        repeat (3) @(negedge clk);
    endtask

    task automatic strobe_stat();
        @(negedge clk); rd_stat = 1'b1;
        @(negedge clk); rd_stat = 1'b0;
    endtask

    task automatic strobe_hi();
        @(negedge clk); rd_hi = 1'b1;
        @(negedge clk); rd_hi = 1'b0;
    endtask

    task automatic strobe_lo();
        @(negedge clk); rd_lo = 1'b1;
        @(negedge clk); rd_lo = 1'b0;
    endtask

    task automatic clear_flag(input string req);
        strobe_stat();
        strobe_lo();
        chk(req, 32'(cap_flag), 32'd0);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 flag in reset", 32'(cap_flag), 32'd0);
        chk("R1 irq in reset", 32'(irq), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 flag after reset", 32'(cap_flag), 32'd0);

        // table walk: R2 rising captures, R3 polarity selection
        for (int i = 0; i < 7; i++) begin
            held = {cap_hi, cap_lo};
            pin_to(VEC[i][2], VEC[i][1]);
            if (VEC[i][0]) begin
                chk("R2 R3 captured value", 32'({cap_hi, cap_lo}), 32'(snap + 16'd1));
                chk("R2 flag set", 32'(cap_flag), 32'd1);
                clear_flag("R8 clear sequence");
            end else begin
                chk("R3 ignored edge value", 32'({cap_hi, cap_lo}), 32'(held));
                chk("R3 ignored edge flag", 32'(cap_flag), 32'd0);
            end
        end

        // R4 newest value kept while flag set; R10 irq follows flag
        irq_en = 1'b1;
        pin_to(1'b1, 1'b0);
        pin_to(1'b1, 1'b1);
        chk("R10 irq with enable", 32'(irq), 32'd1);
        pin_to(1'b1, 1'b0);
        pin_to(1'b1, 1'b1);
        chk("R4 latest capture", 32'({cap_hi, cap_lo}), 32'(snap + 16'd1));
        chk("R4 flag still set", 32'(cap_flag), 32'd1);
        clear_flag("R8 clear after R4");
        chk("R10 irq after clear", 32'(irq), 32'd0);
        irq_en = 1'b0;
        pin_to(1'b1, 1'b0);
        pin_to(1'b1, 1'b1);
        chk("R10 irq masked", 32'(irq), 32'd0);
        chk("R10 flag set under mask", 32'(cap_flag), 32'd1);

        // R9 low read alone keeps the flag; R8 status then low clears it
        strobe_lo();
        chk("R9 flag kept", 32'(cap_flag), 32'd1);
        strobe_stat();
        chk("R8 flag after status read", 32'(cap_flag), 32'd1);
        // R8 new edge after status read cancels the pending clear
        pin_to(1'b1, 1'b0);
        pin_to(1'b1, 1'b1);
        strobe_lo();
        chk("R8 re-set flag survives", 32'(cap_flag), 32'd1);
        clear_flag("R8 clear after re-set");

        // R5 high read blocks transfers until low read
        strobe_hi();
        held = {cap_hi, cap_lo};
        pin_to(1'b1, 1'b0);
        pin_to(1'b1, 1'b1);
        chk("R5 blocked value", 32'({cap_hi, cap_lo}), 32'(held));
        chk("R5 flag during block", 32'(cap_flag), 32'd1);
        strobe_lo();
        pin_to(1'b1, 1'b0);
        pin_to(1'b1, 1'b1);
        chk("R5 released capture", 32'({cap_hi, cap_lo}), 32'(snap + 16'd1));
        clear_flag("R8 clear after R5");

        // R6 low read alone does not block
        strobe_lo();
        pin_to(1'b1, 1'b0);
        pin_to(1'b1, 1'b1);
        chk("R6 capture after lone low read", 32'({cap_hi, cap_lo}), 32'(snap + 16'd1));
        clear_flag("R8 clear after R6");

        // R7 reset keeps the capture register
        pin_to(1'b1, 1'b0);
        held = {cap_hi, cap_lo};
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 value in reset", 32'({cap_hi, cap_lo}), 32'(held));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7 value after reset", 32'({cap_hi, cap_lo}), 32'(held));
        chk("R1 flag after second reset", 32'(cap_flag), 32'd0);
        pin_to(1'b1, 1'b1);
        chk("R1 lock open after reset", 32'({cap_hi, cap_lo}), 32'(snap + 16'd1));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule